// File: doc/BRIEF.md
# Multi-Chain Mux-D Scan Wrapper

This block holds a bank of storage cells that serve as the user's flip-flops in normal operation and as a set of parallel full-scan shift registers during manufacturing test. Each cell has a 2:1 data-select in front of its D input. With test mode low, the cells take the functional data inputs on the user clock. With test mode high, they take the serial bit from the previous cell on a separate scan clock.

The cells are split into a configurable number of independent chains, from one to eight. Each chain has its own serial input and its own serial output. A tester can therefore load and unload all chains at the same time, so a full load takes only as many scan clocks as the longest chain has cells. Every cell output drives the functional output and the next cell in its chain. A global clear input resets every cell asynchronously, in either mode.

The cells are dealt out to the chains in ascending index order. When the cell count does not divide evenly, the leading chains each get one extra cell.

Top module: `scan_chain_bank`

## Requirements
- R1: While `gsr` is high, every cell is cleared to 0 at once, with no clock edge needed and in either mode. `func_q` and `scan_out` therefore read all zeros.
- R2: With `test_mode` = 0, each rising edge of `clk_user` loads `func_d[i]` into cell i, for every i.
- R3: With `test_mode` = 0, edges on `clk_scan` leave every cell unchanged.
- R4: With `test_mode` = 1, each rising edge of `clk_scan` shifts every chain by one place toward its higher index. The lowest-index cell of chain c takes `scan_in[c]`, and `func_d` is ignored.
- R5: With `test_mode` = 1, edges on `clk_user` leave every cell unchanged.
- R6: Chain c has floor(NUM_FF/NUM_CHAINS) cells, plus one more when c < NUM_FF mod NUM_CHAINS. Its cells are a contiguous run of indices that starts just after the last cell of chain c-1, and chain 0 starts at index 0.
- R7: `scan_out[c]` equals, with no register in between, the output of the highest-index cell of chain c. `func_q[i]` is the output of cell i in both modes.
- R8: For a chain of L cells, L scan clocks that load bits b0..bL-1 are followed by L more scan clocks. Read before each of these later edges, `scan_out` yields b0..bL-1 in the order they were loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_user | input | 1 | Functional clock, used when test mode is low |
| clk_scan | input | 1 | Dedicated shift clock, used when test mode is high |
| gsr | input | 1 | Global asynchronous clear, active high |
| test_mode | input | 1 | 1 selects the serial path and the scan clock |
| func_d | input | NUM_FF | Functional data into the cells |
| func_q | output | NUM_FF | Cell outputs toward the user logic |
| scan_in | input | NUM_CHAINS | Serial input of each chain |
| scan_out | output | NUM_CHAINS | Serial output of each chain (last cell) |

## Verification
The default configuration is 20 cells over 3 chains, which gives chains of 7, 7 and 6 cells. Functional capture is tried with all-ones, alternating, walking-one and random words. Each of these patterns exposes a different fault: a stuck bit, a neighbour swap, or a cell wired to the wrong input.

A single 1 shifted into an otherwise empty chain shows where that chain begins. Random serial streams on all chains, with func_d held at random values, separate true shifting from leakage of functional data. Unload of a random stream shows bit order and chain length.

Clock edges on the unselected clock, and a clear applied midway between edges, show that the mode gates the clock and that the clear is asynchronous.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Number of cells assigned to chain idx when total cells are split over n chains.
    // Leading chains absorb the remainder, one extra cell each.
    function automatic int chain_len(input int total, input int n, input int idx);
        int base_len;
        int extra;
        base_len = total / n;
        extra    = total % n;
        return base_len + ((idx < extra) ? 1 : 0);
    endfunction

    // Index of the first cell of chain idx (chains occupy contiguous index runs).
    function automatic int chain_base(input int total, input int n, input int idx);
        int base_len;
        int extra;
        base_len = total / n;
        extra    = total % n;
        return idx * base_len + ((idx < extra) ? idx : extra);
    endfunction

endpackage

// File: rtl/scan_clk_sel.sv
module scan_clk_sel (
    input  logic clk_user_i,
    input  logic clk_scan_i,
    input  logic sel_scan_i,
    output logic clk_o
);

    // Mode changes are expected only while both clocks are low.
    always_comb begin
        clk_o = sel_scan_i ? clk_scan_i : clk_user_i;
    end

endmodule

// File: rtl/scan_dmux.sv
module scan_dmux (
    input  logic sel_ser_i,
    input  logic func_i,
    input  logic ser_i,
    output logic y_o
);

    always_comb begin
        y_o = sel_ser_i ? ser_i : func_i;
    end

endmodule

// File: rtl/scan_chain_seg.sv
module scan_chain_seg #(
    parameter int LEN = 4
) (
    input  logic           clk_i,
    input  logic           gsr_i,
    input  logic           test_mode_i,
    input  logic [LEN-1:0] d_i,
    input  logic           si_i,
    output logic [LEN-1:0] q_o,
    output logic           so_o
);

    typedef struct packed {
        logic [LEN-1:0] cells;
    } seg_state_t;

    seg_state_t     st_d;
    seg_state_t     st_q;
    logic [LEN-1:0] sel_out;

    // One data-select per cell; cell 0 listens to the chain input.
    for (genvar k = 0; k < LEN; k++) begin : g_cell
        if (k == 0) begin : g_head
            scan_dmux u_mux (
                .sel_ser_i (test_mode_i),
                .func_i    (d_i[k]),
                .ser_i     (si_i),
                .y_o       (sel_out[k])
            );
        end else begin : g_body
            scan_dmux u_mux (
                .sel_ser_i (test_mode_i),
                .func_i    (d_i[k]),
                .ser_i     (st_q.cells[k-1]),
                .y_o       (sel_out[k])
            );
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.cells = sel_out;
    end

    always_ff @(posedge clk_i or posedge gsr_i) begin
        if (gsr_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o  = st_q.cells;
    assign so_o = st_q.cells[LEN-1];

    // R1: a clear held across an edge leaves the segment empty
    a_r1_clear_holds: assert property (@(posedge clk_i)
        ($past(gsr_i) && gsr_i) |-> (st_q.cells == '0));

    // R2: functional capture on the selected clock
    a_r2_capture: assert property (@(posedge clk_i) disable iff (gsr_i)
        !test_mode_i |=> (st_q.cells == $past(d_i)));

    // R4: head cell takes the serial input
    a_r4_shift_head: assert property (@(posedge clk_i) disable iff (gsr_i)
        test_mode_i |=> (st_q.cells[0] == $past(si_i)));

    if (LEN > 1) begin : g_body_chk
        // R4: remaining cells take their predecessor
        a_r4_shift_body: assert property (@(posedge clk_i) disable iff (gsr_i)
            test_mode_i |=> (st_q.cells[LEN-1:1] == $past(st_q.cells[LEN-2:0])));
    end

endmodule

// File: rtl/scan_chain_bank.sv
module scan_chain_bank #(
    parameter int NUM_FF     = 20,
    parameter int NUM_CHAINS = 3
) (
    input  logic                  clk_user,
    input  logic                  clk_scan,
    input  logic                  gsr,
    input  logic                  test_mode,
    input  logic [NUM_FF-1:0]     func_d,
    output logic [NUM_FF-1:0]     func_q,
    input  logic [NUM_CHAINS-1:0] scan_in,
    output logic [NUM_CHAINS-1:0] scan_out
);

    logic cell_clk;

    scan_clk_sel u_clk_sel (
        .clk_user_i (clk_user),
        .clk_scan_i (clk_scan),
        .sel_scan_i (test_mode),
        .clk_o      (cell_clk)
    );

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
        localparam int SEG_LEN  = scan_pkg::chain_len(NUM_FF, NUM_CHAINS, c);
        localparam int SEG_BASE = scan_pkg::chain_base(NUM_FF, NUM_CHAINS, c);

        scan_chain_seg #(
            .LEN (SEG_LEN)
        ) u_seg (
            .clk_i       (cell_clk),
            .gsr_i       (gsr),
            .test_mode_i (test_mode),
            .d_i         (func_d[SEG_BASE +: SEG_LEN]),
            .si_i        (scan_in[c]),
            .q_o         (func_q[SEG_BASE +: SEG_LEN]),
            .so_o        (scan_out[c])
        );
    end

    // R1: while the clear is asserted across an edge, all outputs read zero
    a_r1_outputs_clear: assert property (@(posedge cell_clk)
        ($past(gsr) && gsr) |-> ((func_q == '0) && (scan_out == '0)));

endmodule

// File: tb/scan_chain_bank_test.sv
module scan_chain_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_FF     = 20;
    localparam int NUM_CHAINS = 3;

    logic                  clk_user;
    logic                  clk_scan;
    logic                  gsr;
    logic                  test_mode;
    logic [NUM_FF-1:0]     func_d;
    logic [NUM_FF-1:0]     func_q;
    logic [NUM_CHAINS-1:0] scan_in;
    logic [NUM_CHAINS-1:0] scan_out;

    int total_cnt = 0;
    int bad_cnt   = 0;
    bit run_done  = 0;

    // Reference state and chain layout computed independently
    logic [NUM_FF-1:0] mdl;
    int ch_len   [NUM_CHAINS];
    int ch_start [NUM_CHAINS];

    scan_chain_bank #(
        .NUM_FF     (NUM_FF),
        .NUM_CHAINS (NUM_CHAINS)
    ) uut (
        .clk_user  (clk_user),
        .clk_scan  (clk_scan),
        .gsr       (gsr),
        .test_mode (test_mode),
        .func_d    (func_d),
        .func_q    (func_q),
        .scan_in   (scan_in),
        .scan_out  (scan_out)
    );

    task automatic check_val(input string req, input string what, input int got, input int exp);
        total_cnt++;
        if (got != exp) begin
            bad_cnt++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NUM_FF; i++) begin
            check_val(req, $sformatf("func_q[%0d]", i), int'(func_q[i]), int'(mdl[i]));
        end
        for (int c = 0; c < NUM_CHAINS; c++) begin
            check_val("R7", $sformatf("scan_out[%0d]", c), int'(scan_out[c]),
                      int'(mdl[ch_start[c] + ch_len[c] - 1]));
        end
    endtask

    task automatic model_shift();
        for (int c = 0; c < NUM_CHAINS; c++) begin
            for (int k = ch_len[c] - 1; k > 0; k--) begin
                mdl[ch_start[c] + k] = mdl[ch_start[c] + k - 1];
            end
            mdl[ch_start[c]] = scan_in[c];
        end
    endtask

    task automatic pulse_user();
        #(CLK_PERIOD/2);
        clk_user = 1'b1;
        if (!gsr && !test_mode) mdl = func_d;
        #(CLK_PERIOD/2);
        clk_user = 1'b0;
        #1;
    endtask

    task automatic pulse_scan();
        #(CLK_PERIOD/2);
        clk_scan = 1'b1;
        if (!gsr && test_mode) model_shift();
        #(CLK_PERIOD/2);
        clk_scan = 1'b0;
        #1;
    endtask

    function automatic logic [NUM_FF-1:0] rand_word();
        logic [NUM_FF-1:0] w;
        for (int i = 0; i < NUM_FF; i++) w[i] = 1'($urandom);
        return w;
    endfunction

    function automatic logic [NUM_CHAINS-1:0] rand_si();
        return NUM_CHAINS'($urandom);
    endfunction

    task automatic apply_clear(input string req);
        #2;
        gsr = 1'b1;
        mdl = '0;
        #1;
        check_all(req);
        pulse_scan();
        pulse_user();
        check_all(req);
        gsr = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!run_done) begin
            total_cnt++;
            bad_cnt++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin
        logic bq[$];

        // Layout: deal cells round-robin to count lengths, then prefix-sum starts
        for (int c = 0; c < NUM_CHAINS; c++) ch_len[c] = 0;
        for (int i = 0; i < NUM_FF; i++) ch_len[i % NUM_CHAINS]++;
        ch_start[0] = 0;
        for (int c = 1; c < NUM_CHAINS; c++) ch_start[c] = ch_start[c-1] + ch_len[c-1];

        clk_user  = 1'b0;
        clk_scan  = 1'b0;
        gsr       = 1'b0;
        test_mode = 1'b0;
        func_d    = '0;
        scan_in   = '0;
        mdl       = '0;

        // R1: reset state
        apply_clear("R1");

        // R2: functional capture with several patterns
        func_d = '1;                        pulse_user(); check_all("R2");
        for (int i = 0; i < NUM_FF; i++) func_d[i] = i[0];
        pulse_user(); check_all("R2");
        for (int i = 0; i < NUM_FF; i++) begin
            func_d = '0;
            func_d[i] = 1'b1;
            pulse_user(); check_all("R2");
        end
        for (int n = 0; n < 8; n++) begin
            func_d = rand_word(); pulse_user(); check_all("R2");
        end

        // R3: scan clock ignored in functional mode
        for (int n = 0; n < 4; n++) begin
            func_d  = rand_word();
            scan_in = rand_si();
            pulse_scan(); check_all("R3");
        end

        // R1: asynchronous clear in functional mode, with content present
        func_d = '1; pulse_user(); check_all("R2");
        apply_clear("R1");

        // R6: single 1 into each chain lands at that chain's first index
        test_mode = 1'b1;
        #1;
        for (int c = 0; c < NUM_CHAINS; c++) begin
            scan_in = '0;
            scan_in[c] = 1'b1;
            func_d = '1;
            pulse_scan();
            for (int i = 0; i < NUM_FF; i++) begin
                check_val("R6", $sformatf("chain%0d func_q[%0d]", c, i), int'(func_q[i]),
                          (i == ch_start[c]) ? 1 : 0);
            end
            check_all("R6");
            apply_clear("R1");
        end

        // R4: shifting random streams with random func_d
        for (int n = 0; n < 30; n++) begin
            func_d  = rand_word();
            scan_in = rand_si();
            pulse_scan(); check_all("R4");
        end

        // R5: user clock ignored in test mode
        for (int n = 0; n < 4; n++) begin
            func_d = rand_word();
            pulse_user(); check_all("R5");
        end

        // R8: load then unload each chain
        for (int c = 0; c < NUM_CHAINS; c++) begin
            bq.delete();
            for (int k = 0; k < ch_len[c]; k++) begin
                scan_in = rand_si();
                bq.push_back(scan_in[c]);
                func_d = rand_word();
                pulse_scan(); check_all("R4");
            end
            for (int k = 0; k < ch_len[c]; k++) begin
                logic expb;
                expb = bq.pop_front();
                check_val("R8", $sformatf("chain%0d unload bit %0d", c, k),
                          int'(scan_out[c]), int'(expb));
                scan_in = '0;
                pulse_scan(); check_all("R4");
            end
        end

        // R1: asynchronous clear in test mode
        scan_in = '1;
        pulse_scan(); check_all("R4");
        apply_clear("R1");

        // Back to functional mode after test
        test_mode = 1'b0;
        #1;
        func_d = rand_word(); pulse_user(); check_all("R2");

        run_done = 1;
        $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
    end

endmodule